// File: doc/BRIEF.md
# Zero-Index Substituting ALU Stage

This block is the arithmetic and logic stage of a three-address fixed-point datapath that executes instructions of the form rD = rS op rT on 24-bit values. The three 4-bit register indices arrive with the instruction. Index zero never names a real register. Its meaning depends on the field it sits in. In the second-operand field it selects the instruction's immediate constant. In the first-operand field it supplies a literal zero. In the destination field it suppresses the register write, so the operation acts as a compare that only refreshes the condition flags.

The register file, the multiply-accumulate unit and instruction sequencing sit outside the block. The surrounding pipeline supplies the two register read values, the immediate, the indices, the opcode and the condition flag that it has already picked from the flag vector. The block returns the result and a write-enable combinationally in the same cycle. It holds the condition flags in a register that updates at the clock edge that ends the operation.

Because the first operand can be forced to zero, a separate unary group is not needed. The instructions AND, OR, SUB and NOR with a zero first operand give the results zero, copy, negate and bitwise invert.

Top module: `zalu_core`

## Requirements
- R1: Opcode 4'h8 gives rS + rT and opcode 4'h9 gives rS - rT, both wrapped to 24 bits, with `wr_en` high when the destination index is nonzero.
- R2: A second-operand index of 0 replaces the `rt_val` input with the `imm` input in every operation.
- R3: A first-operand index of 0 replaces the `rs_val` input with zero. With opcodes C, D, 9 and E this gives the results 0, K, -K and ~K, where K is the second operand.
- R4: A destination index of 0 holds `wr_en` low, while the flags still update from the operation as for any other destination.
- R5: Opcodes 4'hC, 4'hD, 4'hE and 4'hF give the bitwise AND, OR, NOR and XOR of the two operands. These operations clear overflow.
- R6: Opcode 4'hA copies the second operand and opcode 4'hB copies its two's-complement negation, but only when `cond_flag` is 1. When `cond_flag` is 0, `wr_en` stays low and the flags keep their value.
- R7: Overflow is set when an add, a subtract or a negation does not fit in signed 24 bits. The sign used for the ordered conditions is the sign of the exact result.
- R8: `flags` bit order is [0] eq, [1] ne, [2] ov, [3] nv, [4] ge, [5] gt, [6] le, [7] lt. Each odd bit is the complement of the even bit below it, except that gt = !lt && !eq and le = lt || eq, where all conditions are signed.
- R9: The flags change only at the clock edge after an operation that takes effect. An opcode with bit 3 clear is not an ALU operation: `result` is 0, `wr_en` is 0 and the flags are held.
- R10: A synchronous active-low reset sets the flags to 8'h3A, which means not equal, no overflow, not negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| opcode | input | 4 | Operation code; bit 3 set marks an ALU operation |
| idx_d | input | 4 | Destination register index |
| idx_s | input | 4 | First-operand register index |
| idx_t | input | 4 | Second-operand register index |
| rs_val | input | 24 | Register file value read for idx_s |
| rt_val | input | 24 | Register file value read for idx_t |
| imm | input | 24 | Immediate constant of the instruction |
| cond_flag | input | 1 | Condition flag chosen by the pipeline for conditional copies |
| result | output | 24 | Operation result, valid in the same cycle |
| wr_en | output | 1 | Write the result to register idx_d |
| flags | output | 8 | Registered condition vector in the R8 order |

## Verification
The bench builds the block with its default parameters: 24-bit data, 4-bit indices and 4-bit opcodes. At this size a hand-written vector can reach the signed boundaries, 24'h7FFFFF + 1, 24'h800000 - 1 and the negation of 24'h800000. It can also set each index field to zero on its own or together with the others. The vectors are ordered so that a flag update that should have been suppressed would show a different flag vector from the one left by the previous vector.

// File: rtl/zalu_pkg.sv
// Package: shared opcode encoding and flag-vector bit positions for the
// zero-index substituting ALU stage. Assumes 4-bit opcodes with bit 3
// marking ALU operations.
package zalu_pkg;

    typedef enum logic [3:0] {
        OPC_ADD  = 4'h8,
        OPC_SUB  = 4'h9,
        OPC_CPY  = 4'hA,
        OPC_NCPY = 4'hB,
        OPC_AND  = 4'hC,
        OPC_OR   = 4'hD,
        OPC_NOR  = 4'hE,
        OPC_XOR  = 4'hF
    } zalu_op_e;

    localparam int FLG_EQ = 0;
    localparam int FLG_NE = 1;
    localparam int FLG_OV = 2;
    localparam int FLG_NV = 3;
    localparam int FLG_GE = 4;
    localparam int FLG_GT = 5;
    localparam int FLG_LE = 6;
    localparam int FLG_LT = 7;
    localparam int FLG_W  = 8;

    // Raw status of one operation: zero, true sign, overflow.
    typedef struct packed {
        logic z;
        logic n;
        logic v;
    } zalu_stat_t;

endpackage

// File: rtl/zalu_opnd_sel.sv
// Operand select: turns the two source indices into operands. An index of
// zero in the first field yields a literal zero; in the second field it
// yields the immediate. Assumes register reads are already done outside.
module zalu_opnd_sel #(
    parameter int DATA_W = 24,
    parameter int IDX_W  = 4
) (
    input  logic [IDX_W-1:0]  idx_s,
    input  logic [IDX_W-1:0]  idx_t,
    input  logic [DATA_W-1:0] rs_val,
    input  logic [DATA_W-1:0] rt_val,
    input  logic [DATA_W-1:0] imm,
    output logic [DATA_W-1:0] opa,
    output logic [DATA_W-1:0] opb
);

    localparam logic [IDX_W-1:0] IDX_NONE = '0;

    // First operand: literal zero when the index is zero.
    always_comb begin
        opa = (idx_s == IDX_NONE) ? '0 : rs_val;
    end

    // Second operand: immediate constant when the index is zero.
    always_comb begin
        opb = (idx_t == IDX_NONE) ? imm : rt_val;
    end

endmodule

// File: rtl/zalu_exec.sv
// Execute unit: computes the result and raw status for one operation and
// says whether it takes effect. Assumes two's-complement operands; sums are
// formed one bit wider so the exact sign and overflow come out directly.
module zalu_exec #(
    parameter int DATA_W = 24,
    parameter int OPC_W  = 4
) (
    input  logic [OPC_W-1:0]   opcode,
    input  logic [DATA_W-1:0]  opa,
    input  logic [DATA_W-1:0]  opb,
    input  logic               cond_flag,
    output logic [DATA_W-1:0]  res,
    output zalu_pkg::zalu_stat_t stat,
    output logic               take
);
    import zalu_pkg::*;

    localparam int XW = DATA_W + 1;

    logic [XW-1:0] a_x;
    logic [XW-1:0] b_x;
    logic [XW-1:0] sum_x;
    logic [XW-1:0] dif_x;
    logic [XW-1:0] neg_x;
    logic          is_alu;
    logic          is_cond;
    logic          sgn;
    logic          ovf;
    zalu_op_e      op;

    // Sign-extended wide arithmetic shared by add, subtract and negate.
    always_comb begin
        a_x   = {opa[DATA_W-1], opa};
        b_x   = {opb[DATA_W-1], opb};
        sum_x = a_x + b_x;
        dif_x = a_x - b_x;
        neg_x = '0 - b_x;
    end

    // Opcode classification: ALU marker and conditional-copy group.
    always_comb begin
        op      = zalu_op_e'(opcode);
        is_alu  = opcode[OPC_W-1];
        is_cond = (op == OPC_CPY) || (op == OPC_NCPY);
        take    = is_alu && (!is_cond || cond_flag);
    end

    // Result, exact sign and overflow per operation.
    always_comb begin
        res = '0;
        sgn = 1'b0;
        ovf = 1'b0;
        if (is_alu) begin
            case (op)
                OPC_ADD: begin
                    res = sum_x[DATA_W-1:0];
                    sgn = sum_x[XW-1];
                    ovf = sum_x[XW-1] ^ sum_x[DATA_W-1];
                end
                OPC_SUB: begin
                    res = dif_x[DATA_W-1:0];
                    sgn = dif_x[XW-1];
                    ovf = dif_x[XW-1] ^ dif_x[DATA_W-1];
                end
                OPC_CPY: begin
                    res = opb;
                    sgn = opb[DATA_W-1];
                end
                OPC_NCPY: begin
                    res = neg_x[DATA_W-1:0];
                    sgn = neg_x[XW-1];
                    ovf = neg_x[XW-1] ^ neg_x[DATA_W-1];
                end
                OPC_AND: begin
                    res = opa & opb;
                    sgn = res[DATA_W-1];
                end
                OPC_OR: begin
                    res = opa | opb;
                    sgn = res[DATA_W-1];
                end
                OPC_NOR: begin
                    res = ~(opa | opb);
                    sgn = res[DATA_W-1];
                end
                default: begin
                    res = opa ^ opb;
                    sgn = res[DATA_W-1];
                end
            endcase
        end
    end

    // Pack the raw status for the flag register.
    always_comb begin
        stat.z = (res == '0);
        stat.n = sgn;
        stat.v = ovf;
    end

endmodule

// File: rtl/zalu_flag_reg.sv
// Flag register: holds the status of the last operation that took effect
// and expands it into the eight signed condition codes. Synchronous
// active-low reset to "nonzero, positive, no overflow".
module zalu_flag_reg #(
    parameter int FLAG_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 upd,
    input  zalu_pkg::zalu_stat_t stat_in,
    output logic [FLAG_W-1:0]    flags
);
    import zalu_pkg::*;

    zalu_stat_t st_q;

    // Capture the status when an operation takes effect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else if (upd) begin
            st_q <= stat_in;
        end
    end

    // Expand the stored status into condition / complement pairs.
    always_comb begin
        flags         = '0;
        flags[FLG_EQ] = st_q.z;
        flags[FLG_NE] = !st_q.z;
        flags[FLG_OV] = st_q.v;
        flags[FLG_NV] = !st_q.v;
        flags[FLG_GE] = !st_q.n;
        flags[FLG_LT] = st_q.n;
        flags[FLG_GT] = !st_q.n && !st_q.z;
        flags[FLG_LE] = st_q.n || st_q.z;
    end

endmodule

// File: rtl/zalu_core.sv
// Top of the ALU stage: operand substitution, execution and flag
// register. A zero destination index blocks the write but keeps the flag
// update, which gives compare semantics. Result and write-enable are
// combinational; flags are registered.
module zalu_core #(
    parameter int DATA_W = 24,
    parameter int IDX_W  = 4,
    parameter int OPC_W  = 4,
    parameter int FLAG_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OPC_W-1:0]  opcode,
    input  logic [IDX_W-1:0]  idx_d,
    input  logic [IDX_W-1:0]  idx_s,
    input  logic [IDX_W-1:0]  idx_t,
    input  logic [DATA_W-1:0] rs_val,
    input  logic [DATA_W-1:0] rt_val,
    input  logic [DATA_W-1:0] imm,
    input  logic              cond_flag,
    output logic [DATA_W-1:0] result,
    output logic              wr_en,
    output logic [FLAG_W-1:0] flags
);
    import zalu_pkg::*;

    localparam logic [IDX_W-1:0] IDX_NONE = '0;

    logic [DATA_W-1:0] opa;
    logic [DATA_W-1:0] opb;
    logic              take;
    zalu_stat_t        stat;

    zalu_opnd_sel #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_sel (
        .idx_s  (idx_s),
        .idx_t  (idx_t),
        .rs_val (rs_val),
        .rt_val (rt_val),
        .imm    (imm),
        .opa    (opa),
        .opb    (opb)
    );

    zalu_exec #(.DATA_W(DATA_W), .OPC_W(OPC_W)) u_exec (
        .opcode    (opcode),
        .opa       (opa),
        .opb       (opb),
        .cond_flag (cond_flag),
        .res       (result),
        .stat      (stat),
        .take      (take)
    );

    zalu_flag_reg #(.FLAG_W(FLAG_W)) u_flg (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd     (take),
        .stat_in (stat),
        .flags   (flags)
    );

    // Register write only for effective operations with a real destination.
    always_comb begin
        wr_en = take && (idx_d != IDX_NONE);
    end

endmodule

// File: rtl/zalu_core_chk.sv
// Checker for zalu_core: temporal properties on its ports, attached by bind.
module zalu_core_chk #(
    parameter int DATA_W = 24,
    parameter int IDX_W  = 4,
    parameter int OPC_W  = 4,
    parameter int FLAG_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [OPC_W-1:0]  opcode,
    input logic [IDX_W-1:0]  idx_d,
    input logic              cond_flag,
    input logic [DATA_W-1:0] result,
    input logic              wr_en,
    input logic [FLAG_W-1:0] flags
);

    AST_DEST_ZERO_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_d == '0) |-> !wr_en); // R4

    AST_COND_FALSE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ((opcode == 4'hA || opcode == 4'hB) && !cond_flag) |-> !wr_en); // R6

    AST_COND_FALSE_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ((opcode == 4'hA || opcode == 4'hB) && !cond_flag) |=> $stable(flags)); // R6

    AST_NON_ALU_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !opcode[OPC_W-1] |-> (!wr_en && result == '0)); // R9

    AST_NON_ALU_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !opcode[OPC_W-1] |=> $stable(flags)); // R9

    AST_FLAG_PAIRS: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[0] ^ flags[1]) && (flags[2] ^ flags[3]) && (flags[4] ^ flags[7])); // R8

    AST_RESET_FLAGS: assert property (@(posedge clk)
        !rst_n |=> (flags == 8'h3A)); // R10

endmodule

bind zalu_core zalu_core_chk #(
    .DATA_W(DATA_W), .IDX_W(IDX_W), .OPC_W(OPC_W), .FLAG_W(FLAG_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .opcode    (opcode),
    .idx_d     (idx_d),
    .cond_flag (cond_flag),
    .result    (result),
    .wr_en     (wr_en),
    .flags     (flags)
);

// File: tb/zalu_core_tb.sv
// Bench for zalu_core: a vector table walked by one loop, then directed
// reset tests. Inputs change on the falling edge; result/wr_en are checked
// before the next rising edge, flags just after it.
module zalu_core_tb;

    typedef struct packed {
        logic [3:0]  op;
        logic [3:0]  d;
        logic [3:0]  s;
        logic [3:0]  t;
        logic [23:0] rs;
        logic [23:0] rt;
        logic [23:0] imm;
        logic        cf;
        logic [23:0] res;
        logic        we;
        logic [7:0]  cc;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t TBL [NV] = '{
        '{4'h8, 4'd1, 4'd2, 4'd3, 24'h000010, 24'h000020, 24'h0000FF, 1'b0, 24'h000030, 1'b1, 8'h3A, 8'd1},  // R1 add
        '{4'h9, 4'd1, 4'd2, 4'd3, 24'h000005, 24'h000009, 24'h0000FF, 1'b0, 24'hFFFFFC, 1'b1, 8'hCA, 8'd1},  // R1 sub negative
        '{4'h8, 4'd1, 4'd2, 4'd0, 24'h000100, 24'h777777, 24'h000023, 1'b0, 24'h000123, 1'b1, 8'h3A, 8'd2},  // R2 immediate
        '{4'h9, 4'd1, 4'd0, 4'd3, 24'h123456, 24'h000001, 24'h0000FF, 1'b0, 24'hFFFFFF, 1'b1, 8'hCA, 8'd3},  // R3 negate
        '{4'hD, 4'd4, 4'd0, 4'd0, 24'hABCDEF, 24'h111111, 24'h00F00F, 1'b0, 24'h00F00F, 1'b1, 8'h3A, 8'd3},  // R3 load K
        '{4'hC, 4'd4, 4'd0, 4'd5, 24'hFFFFFF, 24'hFFFFFF, 24'h000000, 1'b0, 24'h000000, 1'b1, 8'h59, 8'd3},  // R3 zero
        '{4'hE, 4'd4, 4'd0, 4'd5, 24'hFFFFFF, 24'h0F0F0F, 24'h000000, 1'b0, 24'hF0F0F0, 1'b1, 8'hCA, 8'd3},  // R3 invert
        '{4'hF, 4'd4, 4'd6, 4'd5, 24'hFF00FF, 24'h0F0F0F, 24'h000000, 1'b0, 24'hF00FF0, 1'b1, 8'hCA, 8'd5},  // R5 xor
        '{4'hC, 4'd2, 4'd6, 4'd5, 24'h00FF00, 24'h0F0F0F, 24'h000000, 1'b0, 24'h000F00, 1'b1, 8'h3A, 8'd5},  // R5 and
        '{4'hD, 4'd2, 4'd6, 4'd5, 24'h800000, 24'h000001, 24'h000000, 1'b0, 24'h800001, 1'b1, 8'hCA, 8'd5},  // R5 or
        '{4'h9, 4'd0, 4'd1, 4'd2, 24'h000007, 24'h000007, 24'h000000, 1'b0, 24'h000000, 1'b0, 8'h59, 8'd4},  // R4 compare equal
        '{4'h8, 4'd3, 4'd1, 4'd2, 24'h7FFFFF, 24'h000001, 24'h000000, 1'b0, 24'h800000, 1'b1, 8'h36, 8'd7},  // R7 add overflow
        '{4'h9, 4'd3, 4'd1, 4'd2, 24'h800000, 24'h000001, 24'h000000, 1'b0, 24'h7FFFFF, 1'b1, 8'hC6, 8'd7},  // R7 sub overflow
        '{4'h9, 4'd0, 4'd1, 4'd2, 24'h000003, 24'h000005, 24'h000000, 1'b0, 24'hFFFFFE, 1'b0, 8'hCA, 8'd8},  // R8 compare less
        '{4'hA, 4'd3, 4'd1, 4'd2, 24'h000000, 24'h000042, 24'h000000, 1'b1, 24'h000042, 1'b1, 8'h3A, 8'd6},  // R6 copy taken
        '{4'hA, 4'd3, 4'd1, 4'd2, 24'h000000, 24'h000000, 24'h000000, 1'b0, 24'h000000, 1'b0, 8'h3A, 8'd6},  // R6 copy skipped
        '{4'hB, 4'd3, 4'd1, 4'd0, 24'h000000, 24'h000000, 24'h000010, 1'b1, 24'hFFFFF0, 1'b1, 8'hCA, 8'd6},  // R6 negate taken
        '{4'hB, 4'd3, 4'd1, 4'd0, 24'h000000, 24'h000000, 24'h000000, 1'b0, 24'h000000, 1'b0, 8'hCA, 8'd6},  // R6 negate skipped
        '{4'h3, 4'd1, 4'd2, 4'd3, 24'h000005, 24'h000005, 24'h000000, 1'b1, 24'h000000, 1'b0, 8'hCA, 8'd9},  // R9 non-ALU
        '{4'hB, 4'd3, 4'd1, 4'd0, 24'h000000, 24'h000000, 24'h800000, 1'b1, 24'h800000, 1'b1, 8'h36, 8'd7},  // R7 negate min
        '{4'hA, 4'd0, 4'd1, 4'd5, 24'h000000, 24'hFFFFFF, 24'h000000, 1'b1, 24'hFFFFFF, 1'b0, 8'hCA, 8'd4}   // R4 conditional, no dest
    };

    logic        clk;
    logic        rst_n;
    logic [3:0]  opcode;
    logic [3:0]  idx_d;
    logic [3:0]  idx_s;
    logic [3:0]  idx_t;
    logic [23:0] rs_val;
    logic [23:0] rt_val;
    logic [23:0] imm;
    logic        cond_flag;
    logic [23:0] result;
    logic        wr_en;
    logic [7:0]  flags;

    int checks;
    int errors;

    zalu_core u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .opcode    (opcode),
        .idx_d     (idx_d),
        .idx_s     (idx_s),
        .idx_t     (idx_t),
        .rs_val    (rs_val),
        .rt_val    (rt_val),
        .imm       (imm),
        .cond_flag (cond_flag),
        .result    (result),
        .wr_en     (wr_en),
        .flags     (flags)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        opcode    = v.op;
        idx_d     = v.d;
        idx_s     = v.s;
        idx_t     = v.t;
        rs_val    = v.rs;
        rt_val    = v.rt;
        imm       = v.imm;
        cond_flag = v.cf;
    endtask

    // Watchdog: a hung run is one failed check and still reports.
    initial begin
        #500000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        checks = 0;
        errors = 0;
        rst_n  = 1'b0;
        drive('0);
        repeat (3) @(posedge clk);
        #1;
        check("R10", "flags after reset", 32'(flags), 32'h3A);
        check("R9", "wr_en idle", 32'(wr_en), 32'h0);

        @(negedge clk);
        rst_n = 1'b1;

        // Table walk: combinational outputs before the edge, flags after it.
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(TBL[i]);
            #1;
            check($sformatf("R%0d", TBL[i].req), $sformatf("result vec %0d", i),
                  32'(result), 32'(TBL[i].res));
            check($sformatf("R%0d", TBL[i].req), $sformatf("wr_en vec %0d", i),
                  32'(wr_en), 32'(TBL[i].we));
            @(posedge clk);
            #1;
            check($sformatf("R%0d", TBL[i].req), $sformatf("flags vec %0d", i),
                  32'(flags), 32'(TBL[i].cc));
        end

        // R10: reset mid-run overrides an ALU operation at the same edge.
        @(negedge clk);
        drive('{4'h8, 4'd3, 4'd1, 4'd2, 24'h7FFFFF, 24'h000001, 24'h0, 1'b0,
                24'h0, 1'b0, 8'h0, 8'd10});
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R10", "flags reset over ALU op", 32'(flags), 32'h3A);

        // R9: after release, a non-ALU opcode leaves the reset flags alone.
        @(negedge clk);
        rst_n = 1'b1;
        drive('{4'h7, 4'd1, 4'd0, 4'd0, 24'h0, 24'h0, 24'h0, 1'b1,
                24'h0, 1'b0, 8'h0, 8'd9});
        @(posedge clk);
        #1;
        check("R9", "flags held on non-ALU", 32'(flags), 32'h3A);

        // R8: equality compare drives eq/le/ge with gt/lt clear.
        @(negedge clk);
        drive('{4'h9, 4'd0, 4'd0, 4'd0, 24'h0, 24'h0, 24'h0, 1'b0,
                24'h0, 1'b0, 8'h0, 8'd8});
        #1;
        check("R4", "wr_en on compare", 32'(wr_en), 32'h0);
        @(posedge clk);
        #1;
        check("R8", "flags 0 - 0", 32'(flags), 32'h59);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule